// File: doc/BRIEF.md
# Operand-Gathering Computation Unit Controller

This block sits in front of a functional unit and follows a single operation from issue to writeback. A one-cycle issue pulse loads the operation fields and raises busy. Each source operand is then fetched through its own release/go handshake with the register file. A port is skipped when its mask bit is set, or when the unit supplies that operand itself: a forced-zero first operand, or an immediate in place of the second.

When every needed operand is in, the controller applies the operand modifiers and presents the operands to the functional unit over a valid/ready handshake. That unit may finish combinationally in the same cycle or take many cycles. The result is latched and held on the data output, and a write release is raised. Busy falls only after the write go has acknowledged that result. The unit never drops a result, and it never lets the functional unit run without busy being high.

Top module: `cu_opgather`

## Requirements
- R1: `busy_o` is low whenever no operation is in flight, is low in the cycle `issue_i` is high, and rises only in the cycle after an `issue_i` pulse.
- R2: The operation fields (`op_type_i`, `op_inv_a_i`, `op_zero_a_i`, `op_imm_i`, `op_imm_ok_i`) are sampled only in the issue cycle. Changing them later has no effect on the operands or the result.
- R3: The read release of a needed port is low in the issue cycle, high from the next cycle, and stays high through any number of stall cycles until that port's go bit is asserted.
- R4: Go may be asserted in the same cycle the release is seen high. The `src_i` slice of that port is then visible on the matching `alu_opnd_o` slice in that same cycle, and the release is low from the following cycle.
- R5: A port never raises its release when its `rd_mask_i` bit is set (bit n is port n), when it is port 0 and zero-a is set, or when it is port 1 and the immediate is valid. A masked port contributes the value 0.
- R6: Operand 0 is first forced to 0 when zero-a is set, then bitwise inverted when invert is set. Operand 1 is replaced by the immediate when the immediate-valid bit is set.
- R7: `busy_o` stays high until the write go has been accepted while the write release is high, and falls in the next cycle. A full operation completes within 50 cycles.
- R8: `wr_rel_o` rises once the functional unit's result has been captured. `data_o` holds that result unchanged while the release is high, and the release clears in the cycle after `wr_go_i`.
- R9: `alu_in_valid_o` is raised only once no read release is outstanding, in the cycle after the last go. The result is captured on `alu_res_valid_i` with `alu_res_ready_o` high, either in the same cycle as the input handshake (zero-delay unit) or any later cycle (multi-cycle unit).
- R10: After reset, busy, every read release, the write release and input-valid are low, and `data_o` is 0.
- R11: With `NUM_RD` = 3, the third port takes part in the read handshake and reaches the functional unit without any modifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_i | input | 1 | One-cycle pulse that starts an operation |
| op_type_i | input | OPC_W | Operation code passed to the functional unit |
| op_inv_a_i | input | 1 | Invert operand 0 |
| op_zero_a_i | input | 1 | Force operand 0 to zero; port 0 is not read |
| op_imm_i | input | DATA_W | Immediate value |
| op_imm_ok_i | input | 1 | Immediate replaces operand 1; port 1 is not read |
| rd_mask_i | input | NUM_RD | Per-port read suppression, held while busy |
| rd_go_i | input | NUM_RD | Per-port read acknowledge |
| src_i | input | NUM_RD*DATA_W | Per-port operand data, port n at bits n*DATA_W |
| busy_o | output | 1 | Operation in flight |
| rd_rel_o | output | NUM_RD | Per-port read request |
| wr_rel_o | output | 1 | Result ready for writeback |
| wr_go_i | input | 1 | Writeback acknowledge |
| data_o | output | DATA_W | Held result |
| alu_op_o | output | OPC_W | Latched operation code |
| alu_opnd_o | output | NUM_RD*DATA_W | Modified operands, port n at bits n*DATA_W |
| alu_in_valid_o | output | 1 | Operands valid to the functional unit |
| alu_in_ready_i | input | 1 | Functional unit accepts operands |
| alu_res_valid_i | input | 1 | Functional unit result valid |
| alu_res_i | input | DATA_W | Functional unit result |
| alu_res_ready_o | output | 1 | Controller accepts the result |

## Verification
The bench builds the unit with three read ports and 16-bit data. The third port therefore takes part in stalls and masking, and the 16-bit inverted-operand sum 65532 can be checked exactly. The bench's own functional-unit model uses the operation code as its latency. Code 0 gives a zero-delay result in the same cycle as the input handshake, and higher codes give multi-cycle results behind a busy input-ready. Both result paths are therefore exercised with staggered read stalls and delayed write acknowledges.

// File: rtl/cu_opgather_pkg.sv
// Shared definitions for the operand-gathering controller.
// Assumes: nothing beyond IEEE 1800-2017.
package cu_opgather_pkg;

    // Life cycle of one operation.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_GATHER = 3'd1,
        ST_EXEC   = 3'd2,
        ST_WAIT   = 3'd3,
        ST_WRITE  = 3'd4
    } cu_state_t;

    // True when a read port must be fetched from the register file.
    function automatic logic port_needed(input int idx, input logic zero_a,
                                         input logic imm_ok);
        if (idx == 0)
            return !zero_a;
        else if (idx == 1)
            return !imm_ok;
        else
            return 1'b1;
    endfunction

endpackage

// File: rtl/cu_read_port.sv
// One read port: holds the pending flag and the gathered operand.
// Assumes: clear_i is a single cycle at issue; mask_i is stable while gathering.
module cu_read_port #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              need_i,
    input  logic              mask_i,
    input  logic              gather_i,
    input  logic              go_i,
    input  logic [DATA_W-1:0] src_i,
    output logic              rel_o,
    output logic              open_o,
    output logic [DATA_W-1:0] opnd_o
);

    logic              pend_q;
    logic [DATA_W-1:0] val_q;
    logic              take;

    // Outstanding means pending and not suppressed by the mask.
    assign open_o = pend_q & ~mask_i;
    assign rel_o  = gather_i & open_o;
    assign take   = rel_o & go_i;

    // Pending flag and operand register, reloaded at issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            val_q  <= '0;
        end else if (clear_i) begin
            pend_q <= need_i;
            val_q  <= '0;
        end else if (take) begin
            pend_q <= 1'b0;
            val_q  <= src_i;
        end
    end

    // Bypass so the operand reaches the unit in the go cycle.
    always_comb begin
        opnd_o = take ? src_i : val_q;
    end

endmodule

// File: rtl/cu_opnd_mod.sv
// Applies operand modifiers: zero then invert on port 0, immediate on port 1.
// Assumes: flags are the latched issue-time values.
module cu_opnd_mod #(
    parameter int DATA_W = 16,
    parameter int NUM_RD = 2
) (
    input  logic [NUM_RD*DATA_W-1:0] raw_i,
    input  logic                     zero_a_i,
    input  logic                     inv_a_i,
    input  logic [DATA_W-1:0]        imm_i,
    input  logic                     imm_ok_i,
    output logic [NUM_RD*DATA_W-1:0] opnd_o
);

    for (genvar p = 0; p < NUM_RD; p++) begin : g_mod
        if (p == 0) begin : g_a
            logic [DATA_W-1:0] a_z;
            // Zero first, invert second.
            always_comb begin
                a_z = zero_a_i ? '0 : raw_i[0 +: DATA_W];
                opnd_o[0 +: DATA_W] = inv_a_i ? ~a_z : a_z;
            end
        end else if (p == 1) begin : g_b
            // Immediate substitution.
            always_comb begin
                opnd_o[DATA_W +: DATA_W] = imm_ok_i ? imm_i : raw_i[DATA_W +: DATA_W];
            end
        end else begin : g_pass
            // Further ports pass through unchanged.
            always_comb begin
                opnd_o[p*DATA_W +: DATA_W] = raw_i[p*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/cu_seq.sv
// Operation sequencer: issue, gather, execute, await result, write back.
// Assumes: issue_i is not raised while busy; unit handshakes are valid/ready.
module cu_seq
    import cu_opgather_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    input  logic remaining_i,
    input  logic alu_in_ready_i,
    input  logic alu_res_valid_i,
    input  logic wr_go_i,
    output logic accept_o,
    output logic gather_o,
    output logic busy_o,
    output logic in_valid_o,
    output logic res_ready_o,
    output logic capture_o,
    output logic wr_rel_o
);

    cu_state_t st_q, st_d;

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:   if (issue_i) st_d = ST_GATHER;
            ST_GATHER: if (!remaining_i) st_d = ST_EXEC;
            ST_EXEC:   if (alu_in_ready_i) st_d = alu_res_valid_i ? ST_WRITE : ST_WAIT;
            ST_WAIT:   if (alu_res_valid_i) st_d = ST_WRITE;
            ST_WRITE:  if (wr_go_i) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Decoded controls.
    always_comb begin
        accept_o    = (st_q == ST_IDLE) & issue_i;
        gather_o    = (st_q == ST_GATHER);
        busy_o      = (st_q != ST_IDLE);
        in_valid_o  = (st_q == ST_EXEC);
        res_ready_o = (st_q == ST_EXEC) | (st_q == ST_WAIT);
        capture_o   = ((st_q == ST_EXEC) & alu_in_ready_i & alu_res_valid_i)
                    | ((st_q == ST_WAIT) & alu_res_valid_i);
        wr_rel_o    = (st_q == ST_WRITE);
    end

endmodule

// File: rtl/cu_opgather.sv
// Computation unit controller: tracks one operation from issue to writeback.
// Assumes: rd_mask_i held stable while busy; issue_i only pulsed when idle.
module cu_opgather
    import cu_opgather_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NUM_RD = 2,
    parameter int OPC_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_i,
    input  logic [OPC_W-1:0]         op_type_i,
    input  logic                     op_inv_a_i,
    input  logic                     op_zero_a_i,
    input  logic [DATA_W-1:0]        op_imm_i,
    input  logic                     op_imm_ok_i,
    input  logic [NUM_RD-1:0]        rd_mask_i,
    input  logic [NUM_RD-1:0]        rd_go_i,
    input  logic [NUM_RD*DATA_W-1:0] src_i,
    output logic                     busy_o,
    output logic [NUM_RD-1:0]        rd_rel_o,
    output logic                     wr_rel_o,
    input  logic                     wr_go_i,
    output logic [DATA_W-1:0]        data_o,
    output logic [OPC_W-1:0]         alu_op_o,
    output logic [NUM_RD*DATA_W-1:0] alu_opnd_o,
    output logic                     alu_in_valid_o,
    input  logic                     alu_in_ready_i,
    input  logic                     alu_res_valid_i,
    input  logic [DATA_W-1:0]        alu_res_i,
    output logic                     alu_res_ready_o
);

    localparam int OPND_W = NUM_RD * DATA_W;

    logic              accept, gather, capture;
    logic [NUM_RD-1:0] open_v;
    logic [OPND_W-1:0] raw_opnd;
    logic              remaining;

    logic [OPC_W-1:0]  op_q;
    logic              inv_q, zero_q, imm_ok_q;
    logic [DATA_W-1:0] imm_q;
    logic [DATA_W-1:0] res_q;

    // Latch the operation fields at an accepted issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            inv_q    <= 1'b0;
            zero_q   <= 1'b0;
            imm_q    <= '0;
            imm_ok_q <= 1'b0;
        end else if (accept) begin
            op_q     <= op_type_i;
            inv_q    <= op_inv_a_i;
            zero_q   <= op_zero_a_i;
            imm_q    <= op_imm_i;
            imm_ok_q <= op_imm_ok_i;
        end
    end

    // One read port per source operand.
    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        cu_read_port #(.DATA_W(DATA_W)) i_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (accept),
            .need_i   (port_needed(p, op_zero_a_i, op_imm_ok_i)),
            .mask_i   (rd_mask_i[p]),
            .gather_i (gather),
            .go_i     (rd_go_i[p]),
            .src_i    (src_i[p*DATA_W +: DATA_W]),
            .rel_o    (rd_rel_o[p]),
            .open_o   (open_v[p]),
            .opnd_o   (raw_opnd[p*DATA_W +: DATA_W])
        );
    end

    // Any port still outstanding after this cycle's go bits.
    assign remaining = |(open_v & ~rd_go_i);

    cu_opnd_mod #(.DATA_W(DATA_W), .NUM_RD(NUM_RD)) i_mod (
        .raw_i    (raw_opnd),
        .zero_a_i (zero_q),
        .inv_a_i  (inv_q),
        .imm_i    (imm_q),
        .imm_ok_i (imm_ok_q),
        .opnd_o   (alu_opnd_o)
    );

    cu_seq i_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .issue_i         (issue_i),
        .remaining_i     (remaining),
        .alu_in_ready_i  (alu_in_ready_i),
        .alu_res_valid_i (alu_res_valid_i),
        .wr_go_i         (wr_go_i),
        .accept_o        (accept),
        .gather_o        (gather),
        .busy_o          (busy_o),
        .in_valid_o      (alu_in_valid_o),
        .res_ready_o     (alu_res_ready_o),
        .capture_o       (capture),
        .wr_rel_o        (wr_rel_o)
    );

    // Result holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)       res_q <= '0;
        else if (capture) res_q <= alu_res_i;
    end

    assign data_o   = res_q;
    assign alu_op_o = op_q;

endmodule

// File: rtl/cu_opgather_chk.sv
// Protocol checker for cu_opgather, attached by bind.
// Assumes: synchronous active-low reset held from time zero.
module cu_opgather_chk #(
    parameter int DATA_W = 16,
    parameter int NUM_RD = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic              busy_o,
    input logic [NUM_RD-1:0] rd_rel_o,
    input logic [NUM_RD-1:0] rd_go_i,
    input logic              wr_rel_o,
    input logic              wr_go_i,
    input logic [DATA_W-1:0] data_o,
    input logic              alu_in_valid_o
);

    a_r1_no_issue_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && issue_i));

    a_r1_busy_rise_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(issue_i));

    a_r7_busy_falls_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(wr_rel_o && wr_go_i));

    a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rel_o && !wr_go_i) |=> (wr_rel_o && $stable(data_o)));

    a_r8_wr_rel_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rel_o && wr_go_i) |=> !wr_rel_o);

    a_r9_valid_after_gather: assert property (@(posedge clk) disable iff (!rst_n)
        alu_in_valid_o |-> (rd_rel_o == '0));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ((rd_rel_o == '0) && !wr_rel_o && !alu_in_valid_o));

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port_chk
        a_r3_rel_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_rel_o[p] && !rd_go_i[p]) |=> rd_rel_o[p]);

        a_r4_rel_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_rel_o[p] && rd_go_i[p]) |=> !rd_rel_o[p]);
    end

endmodule

bind cu_opgather cu_opgather_chk #(.DATA_W(DATA_W), .NUM_RD(NUM_RD)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .issue_i        (issue_i),
    .busy_o         (busy_o),
    .rd_rel_o       (rd_rel_o),
    .rd_go_i        (rd_go_i),
    .wr_rel_o       (wr_rel_o),
    .wr_go_i        (wr_go_i),
    .data_o         (data_o),
    .alu_in_valid_o (alu_in_valid_o)
);

// File: tb/test_cu_opgather.sv
`timescale 1ns/1ps
// Bench for cu_opgather: functional-unit model, per-clock reference model, directed operations.
module test_cu_opgather;

    localparam int DW = 16;
    localparam int NR = 3;
    localparam int OW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_i = 1'b0;
    logic [OW-1:0] op_type_i = '0;
    logic          op_inv_a_i = 1'b0;
    logic          op_zero_a_i = 1'b0;
    logic [DW-1:0] op_imm_i = '0;
    logic          op_imm_ok_i = 1'b0;
    logic [NR-1:0] rd_mask_i = '0;
    logic [NR-1:0] rd_go_i = '0;
    logic [DW-1:0] src_arr [NR];
    logic [NR*DW-1:0] src_i;
    logic          busy_o;
    logic [NR-1:0] rd_rel_o;
    logic          wr_rel_o;
    logic          wr_go_i = 1'b0;
    logic [DW-1:0] data_o;
    logic [OW-1:0] alu_op_o;
    logic [NR*DW-1:0] alu_opnd_o;
    logic          alu_in_valid_o;
    logic          alu_in_ready_i;
    logic          alu_res_valid_i;
    logic [DW-1:0] alu_res_i;
    logic          alu_res_ready_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    initial for (int p = 0; p < NR; p++) src_arr[p] = '0;

    always_comb begin
        for (int p = 0; p < NR; p++) src_i[p*DW +: DW] = src_arr[p];
    end

    cu_opgather #(.DATA_W(DW), .NUM_RD(NR), .OPC_W(OW)) i_cu_opgather (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_type_i(op_type_i),
        .op_inv_a_i(op_inv_a_i), .op_zero_a_i(op_zero_a_i), .op_imm_i(op_imm_i),
        .op_imm_ok_i(op_imm_ok_i), .rd_mask_i(rd_mask_i), .rd_go_i(rd_go_i),
        .src_i(src_i), .busy_o(busy_o), .rd_rel_o(rd_rel_o), .wr_rel_o(wr_rel_o),
        .wr_go_i(wr_go_i), .data_o(data_o), .alu_op_o(alu_op_o),
        .alu_opnd_o(alu_opnd_o), .alu_in_valid_o(alu_in_valid_o),
        .alu_in_ready_i(alu_in_ready_i), .alu_res_valid_i(alu_res_valid_i),
        .alu_res_i(alu_res_i), .alu_res_ready_o(alu_res_ready_o)
    );

    // Functional-unit model: operation code is the latency, 0 means zero-delay.
    logic          fu_busy;
    int            fu_cnt;
    logic [DW-1:0] fu_hold;
    logic [DW-1:0] fu_sum;

    always_comb begin
        fu_sum = alu_opnd_o[0 +: DW] + alu_opnd_o[DW +: DW] + alu_opnd_o[2*DW +: DW];
        if (alu_op_o == '0) begin
            alu_in_ready_i  = 1'b1;
            alu_res_valid_i = alu_in_valid_o;
            alu_res_i       = fu_sum;
        end else begin
            alu_in_ready_i  = !fu_busy;
            alu_res_valid_i = fu_busy && (fu_cnt == 0);
            alu_res_i       = fu_hold;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            fu_busy <= 1'b0;
            fu_cnt  <= 0;
            fu_hold <= '0;
        end else if (alu_in_valid_o && alu_in_ready_i && alu_op_o != '0) begin
            fu_busy <= 1'b1;
            fu_cnt  <= int'(alu_op_o) - 1;
            fu_hold <= fu_sum;
        end else if (fu_busy) begin
            if (fu_cnt != 0) fu_cnt <= fu_cnt - 1;
            else if (alu_res_ready_o) fu_busy <= 1'b0;
        end
    end

    // Reference model of the handshake, advanced on each rising edge.
    int            m_phase = 0;
    logic          m_busy = 1'b0;
    logic [NR-1:0] m_rel = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_busy = 1'b0; m_rel = '0;
        end else begin
            case (m_phase)
                0: if (issue_i) begin
                       m_busy = 1'b1;
                       for (int p = 0; p < NR; p++)
                           m_rel[p] = !rd_mask_i[p] &&
                               ((p == 0) ? !op_zero_a_i : (p == 1) ? !op_imm_ok_i : 1'b1);
                       m_phase = 1;
                   end
                1: begin
                       if ((m_rel & ~rd_go_i) == '0) m_phase = 2;
                       m_rel = m_rel & ~rd_go_i;
                   end
                2: if (alu_in_ready_i) m_phase = alu_res_valid_i ? 4 : 3;
                3: if (alu_res_valid_i) m_phase = 4;
                4: if (wr_go_i) begin m_phase = 0; m_busy = 1'b0; end
                default: m_phase = 0;
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R1 R3 R8 R9).
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            logic [NR+2:0] act, exp;
            act = {busy_o, rd_rel_o, alu_in_valid_o, wr_rel_o};
            exp = {m_busy, m_rel, m_phase == 2, m_phase == 4};
            check(act == exp, "R1 R3 R8 R9 model", 32'(act), 32'(exp));
        end
    end

    // One read port of the register-file side.
    task automatic port_proc(input int q, input bit req, input int stall,
                             input logic [DW-1:0] val);
        if (!req) begin
            check(rd_rel_o[q] == 1'b0, "R5 suppressed release", 32'(rd_rel_o[q]), 0);
            return;
        end
        check(rd_rel_o[q] == 1'b1, "R3 release after issue", 32'(rd_rel_o[q]), 1);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            check(rd_rel_o[q] == 1'b1, "R3 release through stall", 32'(rd_rel_o[q]), 1);
        end
        rd_go_i[q] = 1'b1;
        src_arr[q] = val;
        #1;
        if (q != 0)
            check(alu_opnd_o[q*DW +: DW] == val, (q == 2) ? "R4 R11 operand bypass" :
                  "R4 operand bypass", 32'(alu_opnd_o[q*DW +: DW]), 32'(val));
        @(negedge clk);
        rd_go_i[q] = 1'b0;
        src_arr[q] = '0;
        check(rd_rel_o[q] == 1'b0, "R4 release drops", 32'(rd_rel_o[q]), 0);
    endtask

    // Issue one operation and carry it through writeback.
    task automatic run_op(input logic [DW-1:0] a, b, c, input logic [OW-1:0] op,
                          input bit inv, zero, input logic [DW-1:0] imm, input bit immok,
                          input logic [NR-1:0] mask, input int st0, st1, st2, wst,
                          input string tag);
        logic [DW-1:0] ea, eb, ec, exp;
        logic [NR-1:0] req;
        int k;
        ea  = (zero || mask[0]) ? '0 : a;
        ea  = inv ? ~ea : ea;
        eb  = immok ? imm : (mask[1] ? '0 : b);
        ec  = mask[2] ? '0 : c;
        exp = ea + eb + ec;
        req = {!mask[2], !mask[1] && !immok, !mask[0] && !zero};

        @(negedge clk);
        rd_mask_i   = mask;
        op_type_i   = op;
        op_inv_a_i  = inv;
        op_zero_a_i = zero;
        op_imm_i    = imm;
        op_imm_ok_i = immok;
        issue_i     = 1'b1;
        #1;
        check(busy_o == 1'b0, "R1 busy low in issue cycle", 32'(busy_o), 0);
        check(rd_rel_o == '0, "R3 release low in issue cycle", 32'(rd_rel_o), 0);
        @(negedge clk);
        issue_i     = 1'b0;
        op_type_i   = op ^ 3'd1;
        op_inv_a_i  = !inv;
        op_zero_a_i = !zero;
        op_imm_i    = ~imm;
        op_imm_ok_i = !immok;
        check(busy_o == 1'b1, "R1 busy after issue", 32'(busy_o), 1);
        fork
            port_proc(0, req[0], st0, a);
            port_proc(1, req[1], st1, b);
            port_proc(2, req[2], st2, c);
        join
        k = 0;
        while (!wr_rel_o && k < 50) begin
            @(negedge clk);
            k++;
        end
        check(wr_rel_o == 1'b1, "R7 completes within 50 cycles", 32'(wr_rel_o), 1);
        check(data_o == exp, tag, 32'(data_o), 32'(exp));
        for (int s = 0; s < wst; s++) begin
            @(negedge clk);
            check(data_o == exp && wr_rel_o && busy_o, "R8 result held",
                  32'(data_o), 32'(exp));
        end
        wr_go_i = 1'b1;
        @(negedge clk);
        wr_go_i = 1'b0;
        check(!wr_rel_o && !busy_o, "R7 R8 release and busy clear",
              32'({wr_rel_o, busy_o}), 0);
        rd_mask_i = '0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && rd_rel_o == '0 && !wr_rel_o && !alu_in_valid_o,
              "R10 control outputs after reset",
              32'({busy_o, rd_rel_o, wr_rel_o, alu_in_valid_o}), 0);
        check(data_o == '0, "R10 data after reset", 32'(data_o), 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!busy_o, "R1 busy stays low while idle", 32'(busy_o), 0);
        end
        // Plain add, zero-delay unit, third port masked.
        run_op(16'd5, 16'd2, 16'd0, 3'd0, 0, 0, 16'd0, 0, 3'b100, 0, 0, 0, 0, "R9 zero-delay sum");
        // Inverted operand 0: ~5 + 2 = 65532.
        run_op(16'd5, 16'd2, 16'd0, 3'd0, 1, 0, 16'd0, 0, 3'b100, 0, 0, 0, 1, "R6 inverted operand");
        // Zero-a and immediate together: no port read at all.
        run_op(16'd5, 16'd2, 16'd0, 3'd1, 0, 1, 16'd8, 1, 3'b100, 0, 0, 0, 0, "R5 R6 no read ports");
        // Immediate replaces operand 1; third port read; multi-cycle unit.
        run_op(16'd5, 16'd2, 16'd1, 3'd2, 0, 0, 16'd8, 1, 3'b000, 2, 0, 1, 2, "R6 R11 immediate sum");
        // Zero-a, ports 1 and 2 read, long latency.
        run_op(16'd5, 16'd2, 16'd3, 3'd3, 0, 1, 16'd0, 0, 3'b000, 0, 4, 0, 0, "R6 R9 zero-a multi-cycle");
        // All three ports with staggered stalls and a delayed write go.
        run_op(16'd100, 16'd200, 16'd7, 3'd1, 0, 0, 16'd0, 0, 3'b000, 0, 3, 1, 4, "R3 R9 staggered stalls");
        // Mask on port 1 supplies zero.
        run_op(16'd9, 16'd77, 16'd4, 3'd0, 0, 0, 16'd0, 0, 3'b010, 1, 0, 2, 0, "R5 masked port is zero");
        // Zero then invert gives all ones.
        run_op(16'd123, 16'd2, 16'd0, 3'd2, 1, 1, 16'd0, 0, 3'b000, 0, 0, 0, 1, "R6 zero then invert");
        // Fields scrambled after issue inside run_op; result follows issue-time fields.
        run_op(16'd40, 16'd2, 16'd0, 3'd0, 0, 0, 16'd1000, 0, 3'b100, 5, 1, 0, 0, "R2 fields latched at issue");
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        wait (cycles > 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule